// File: doc/BRIEF.md
# Scan-Port Debug Reset and Interrupt Controller

This block extends a standard test access port so that a debugger can act on the chip through scan instructions alone. A 4-bit instruction register, filled through the usual shift path, selects one of three debug actions. One instruction drives a chip reset request. A second instruction withdraws it, so the reset stays held between the two. A third instruction raises a debug interrupt request that stays set until software clears it.

The TAP controller runs on TCK. The interrupt request, its software clear and the reset hold timer run on the system clock. The TCK-side events reach the system clock through two-flop synchronisers and edge detectors. A hold flag shows when the reset has been held for at least the minimum power-on reset time, counted in system clocks. While the interrupt request is pending, the interrupt-code output carries the exception code 0x600.

The TAP controller has sixteen states: Test-Logic-Reset (TLR), Run-Test/Idle (RTI), and for each of the DR and IR columns Select, Capture, Shift, Exit1, Pause, Exit2 and Update. With TMS high the transitions are: TLR→TLR, RTI→Select-DR, Select-DR→Select-IR, Select-IR→TLR, Capture→Exit1, Shift→Exit1, Exit1→Update, Pause→Exit2, Exit2→Update, and Update→Select-DR. With TMS low they are: TLR→RTI, RTI→RTI, Select-DR→Capture-DR, Select-IR→Capture-IR, Capture→Shift, Shift→Shift, Exit1→Pause, Pause→Pause, Exit2→Shift, and Update→RTI.

Top module: `dbg_tap_ctrl`

## Requirements
- R1: The TAP controller follows the sixteen-state machine above on rising TCK. A low level on `trst_n` forces TLR asynchronously. Every rising TCK edge taken in TLR reloads the instruction register with BYPASS (4'b1111).
- R2: Capture-IR loads 4'b0001 into the IR shift stage, and the IR is shifted LSB first. Any instruction value other than 4'b0110, 4'b0111 and 4'b0101 acts as BYPASS. BYPASS selects a 1-bit register that captures 0.
- R3: Updating the IR with 4'b0110 sets `dbg_reset_o` to 1 on that TCK edge. Updating the IR with 4'b0111 clears it to 0. No other instruction changes it.
- R4: `hold_met_o` rises once the synchronised reset request has been high for HOLD_CYC system clocks. It returns to 0 once the synchronised request is low.
- R5: Updating the IR with 4'b0101 sets `irq_o` within four system clocks of that TCK edge. While `irq_o` is 1, `irq_code_o` is 12'h600; otherwise it is 0.
- R6: `irq_o` stays at 1 until a rising edge on `sw_clr` clears it, within four system clocks of that edge. Loading other instructions does not clear it.
- R7: While the IR holds 4'b0101, a 1-bit interrupt data register lies between `tdi` and `tdo`, and it captures 1 in Capture-DR. TDO changes on falling TCK and is 0 outside the Shift states.
- R8: Entering TLR, whether through TMS or through `trst_n`, leaves `dbg_reset_o` and `irq_o` unchanged.
- R9: When a set event and a clear event reach the request flag in the same system clock, the set wins and `irq_o` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Test data out, changes on falling TCK |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| sw_clr | input | 1 | Software clear of the interrupt request (rising edge) |
| dbg_reset_o | output | 1 | Debug chip reset request, active high |
| irq_o | output | 1 | Sticky debug interrupt request |
| irq_code_o | output | 12 | Exception code, 0x600 while a request is pending |
| hold_met_o | output | 1 | Minimum reset hold time has elapsed |

## Verification
`dbg_reset_o` follows the rising TCK edge at which the TAP leaves Update-IR. The bench therefore checks it half a TCK period after the last step of a scan. `irq_o` is due three to four system clocks after that same edge: two synchroniser flops, one edge-detect flop and the flag itself. A clear takes the same path from the rising edge of `sw_clr`. The bench waits at least six system clocks before it samples either result, and it drives the colliding clear on the very system-clock phase as the update edge, so that both events arrive together. `hold_met_o` is due HOLD_CYC plus three system clocks after the reset request rises. It is sampled once well before that point and once well after it. TDO is read just before each rising TCK edge, half a period after the falling edge that set it.

// File: rtl/dbgtap_pkg.sv
`timescale 1ns/100ps
package dbgtap_pkg;
    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] OP_RST_ON  = 4'b0110;
    localparam logic [IR_W-1:0] OP_RST_OFF = 4'b0111;
    localparam logic [IR_W-1:0] OP_DBG_INT = 4'b0101;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/100ps
module tap_fsm
    import dbgtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_tlr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       sh_dr
);
    tap_state_e nxt;

    // state register (R1)
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // output decode
    always_comb begin
        in_tlr = (state == ST_TLR);
        cap_ir = (state == ST_CAP_IR);
        sh_ir  = (state == ST_SH_IR);
        upd_ir = (state == ST_UPD_IR);
        cap_dr = (state == ST_CAP_DR);
        sh_dr  = (state == ST_SH_DR);
    end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/100ps
module tap_ir
    import dbgtap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            sys_rst_n,
    input  logic            tdi,
    input  logic            in_tlr,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_tdo,
    output logic            sel_int,
    output logic            rst_req,
    output logic            int_upd
);
    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= OP_BYPASS;
        end else begin
            if (cap_ir)     ir_sr <= IR_CAPTURE;
            else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (in_tlr)      ir_q <= OP_BYPASS;
            else if (upd_ir) ir_q <= ir_sr;
        end
    end

    // one-TCK-period pulse marking an interrupt instruction update (R5)
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) int_upd <= 1'b0;
        else         int_upd <= upd_ir && (ir_sr == OP_DBG_INT);
    end

    // reset request survives TLR and TRST; only system reset clears it (R3, R8)
    always_ff @(posedge tck or negedge sys_rst_n) begin
        if (!sys_rst_n) rst_req <= 1'b0;
        else if (upd_ir) begin
            if (ir_sr == OP_RST_ON)       rst_req <= 1'b1;
            else if (ir_sr == OP_RST_OFF) rst_req <= 1'b0;
        end
    end

    assign ir_tdo  = ir_sr[0];
    assign sel_int = (ir_q == OP_DBG_INT);
endmodule

// File: rtl/dbg_sync.sv
`timescale 1ns/100ps
module dbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbg_sys_side.sv
`timescale 1ns/100ps
module dbg_sys_side #(
    parameter int HOLD_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic int_upd,
    input  logic rst_req,
    input  logic sw_clr,
    output logic irq,
    output logic hold_met,
    output logic set_evt,
    output logic clr_evt,
    output logic rst_sync
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic upd_s, upd_prev, clr_s, clr_prev;
    logic [CW-1:0] cnt;

    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_upd (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(int_upd), .q(upd_s));
    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(sw_clr), .q(clr_s));
    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(rst_req), .q(rst_sync));

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            upd_prev <= 1'b0;
            clr_prev <= 1'b0;
        end else begin
            upd_prev <= upd_s;
            clr_prev <= clr_s;
        end
    end

    assign set_evt = upd_s & ~upd_prev;
    assign clr_evt = clr_s & ~clr_prev;

    // sticky request, set has priority (R5, R6, R9)
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n)   irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (clr_evt) irq <= 1'b0;
    end

    // reset hold timer (R4)
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n)     cnt <= '0;
        else if (!rst_sync) cnt <= '0;
        else if (!hold_met) cnt <= cnt + 1'b1;
    end

    assign hold_met = (cnt == CW'(HOLD_CYC));
endmodule

// File: rtl/dbg_tap_ctrl.sv
`timescale 1ns/100ps
module dbg_tap_ctrl
    import dbgtap_pkg::*;
#(
    parameter int          HOLD_CYC = 64,
    parameter int          CODE_W   = 12,
    parameter logic [11:0] IRQ_CODE = 12'h600
) (
    input  logic              tck,
    input  logic              tms,
    input  logic              tdi,
    input  logic              trst_n,
    output logic              tdo,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              sw_clr,
    output logic              dbg_reset_o,
    output logic              irq_o,
    output logic [CODE_W-1:0] irq_code_o,
    output logic              hold_met_o
);
    tap_state_e      tap_state;
    logic            in_tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr;
    logic [IR_W-1:0] ir_q;
    logic            ir_tdo, sel_int, int_upd;
    logic            set_evt, clr_evt, rst_sync;
    logic            byp_dr, int_dr, tdo_nxt;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state),
        .in_tlr(in_tlr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .sh_dr(sh_dr));

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .sys_rst_n(sys_rst_n), .tdi(tdi),
        .in_tlr(in_tlr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .ir_q(ir_q), .ir_tdo(ir_tdo), .sel_int(sel_int),
        .rst_req(dbg_reset_o), .int_upd(int_upd));

    dbg_sys_side #(.HOLD_CYC(HOLD_CYC)) u_sys (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .int_upd(int_upd),
        .rst_req(dbg_reset_o), .sw_clr(sw_clr), .irq(irq_o),
        .hold_met(hold_met_o), .set_evt(set_evt), .clr_evt(clr_evt),
        .rst_sync(rst_sync));

    // 1-bit data registers: bypass captures 0, interrupt register captures 1 (R2, R7)
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_dr <= 1'b0;
            int_dr <= 1'b0;
        end else if (cap_dr) begin
            byp_dr <= 1'b0;
            int_dr <= 1'b1;
        end else if (sh_dr) begin
            byp_dr <= tdi;
            int_dr <= tdi;
        end
    end

    always_comb begin
        if (sh_ir)      tdo_nxt = ir_tdo;
        else if (sh_dr) tdo_nxt = sel_int ? int_dr : byp_dr;
        else            tdo_nxt = 1'b0;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) tdo <= 1'b0;
        else         tdo <= tdo_nxt;
    end

    assign irq_code_o = irq_o ? CODE_W'(IRQ_CODE) : '0;
endmodule

// File: rtl/dbg_tap_ctrl_chk.sv
`timescale 1ns/100ps
module dbg_tap_ctrl_chk
    import dbgtap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            sys_clk,
    input logic            sys_rst_n,
    input tap_state_e      tap_state,
    input logic [IR_W-1:0] ir_q,
    input logic            dbg_reset_o,
    input logic            irq_o,
    input logic [11:0]     irq_code_o,
    input logic            hold_met_o,
    input logic            set_evt,
    input logic            clr_evt,
    input logic            rst_sync
);
    p_tlr_bypass_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == ST_TLR) |=> (ir_q == OP_BYPASS));

    p_tlr_keeps_reset_r8: assert property (@(posedge tck) disable iff (!trst_n || !sys_rst_n)
        (tap_state == ST_TLR) |=> $stable(dbg_reset_o));

    p_hold_drop_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !rst_sync |=> !hold_met_o);

    p_code_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(irq_o) |-> (irq_code_o == 12'h600));

    p_sticky_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (irq_o && !clr_evt) |=> irq_o);

    p_clear_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (clr_evt && !set_evt) |=> !irq_o);

    p_set_wins_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        set_evt |=> irq_o);
endmodule

bind dbg_tap_ctrl dbg_tap_ctrl_chk u_chk (
    .tck(tck), .trst_n(trst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .tap_state(tap_state), .ir_q(ir_q), .dbg_reset_o(dbg_reset_o),
    .irq_o(irq_o), .irq_code_o(irq_code_o), .hold_met_o(hold_met_o),
    .set_evt(set_evt), .clr_evt(clr_evt), .rst_sync(rst_sync));

// File: tb/dbg_tap_ctrl_test.sv
`timescale 1ns/100ps
module dbg_tap_ctrl_test;
    localparam int HOLD = 20;
    localparam logic [3:0] I_BYP = 4'b1111, I_RON = 4'b0110, I_ROFF = 4'b0111,
                           I_INT = 4'b0101, I_ODD = 4'b0011;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
    logic sys_rst_n = 1'b0, sw_clr = 1'b0;
    logic tdo, dbg_reset_o, irq_o, hold_met_o;
    logic [11:0] irq_code_o;
    logic clr_arm = 1'b0;
    logic done = 1'b0;
    int n_chk = 0, n_fail = 0;

    dbg_tap_ctrl #(.HOLD_CYC(HOLD)) uut (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
        .sys_clk(clk), .sys_rst_n(sys_rst_n), .sw_clr(sw_clr),
        .dbg_reset_o(dbg_reset_o), .irq_o(irq_o), .irq_code_o(irq_code_o),
        .hold_met_o(hold_met_o));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tap_step(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        repeat (4) @(posedge clk);
        #1;
        o = tdo;
        tck = 1'b1;
        if (clr_arm) begin sw_clr = 1'b1; clr_arm = 1'b0; end
        repeat (4) @(posedge clk);
        #1;
        tck = 1'b0;
    endtask

    task automatic ir_scan(input logic [3:0] code, input bit clr_at_upd,
                           output logic [3:0] cap);
        logic o;
        tap_step(1, 0, o); tap_step(1, 0, o); tap_step(0, 0, o); tap_step(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tap_step(i == 3, code[i], o);
            cap[i] = o;
        end
        tap_step(1, 0, o);
        clr_arm = clr_at_upd;
        tap_step(0, 0, o);
    endtask

    task automatic dr_scan(input logic [2:0] bits, output logic [2:0] seen);
        logic o;
        tap_step(1, 0, o); tap_step(0, 0, o); tap_step(0, 0, o);
        for (int i = 0; i < 3; i++) begin
            tap_step(i == 2, bits[i], o);
            seen[i] = o;
        end
        tap_step(1, 0, o); tap_step(0, 0, o);
    endtask

    task automatic t_reset_state();
        chk(dbg_reset_o == 0 && irq_o == 0 && hold_met_o == 0, "R3 reset state",
            {dbg_reset_o, irq_o, hold_met_o}, 0);
        chk(irq_code_o == 0 && tdo == 0, "R5 reset code/tdo", {irq_code_o, tdo}, 0);
    endtask

    task automatic t_ir_capture();
        logic [3:0] c; logic [2:0] s;
        ir_scan(I_BYP, 0, c);
        chk(c == 4'b0001, "R2 IR capture", c, 4'b0001);
        dr_scan(3'b101, s);
        chk(s == 3'b010, "R2 bypass path", s, 3'b010);
    endtask

    task automatic t_reset_ctrl();
        logic [3:0] c;
        ir_scan(I_RON, 0, c);
        chk(dbg_reset_o == 1, "R3 reset assert", dbg_reset_o, 1);
        repeat (10) @(posedge clk); #1;
        chk(hold_met_o == 0, "R4 hold early", hold_met_o, 0);
        repeat (20) @(posedge clk); #1;
        chk(hold_met_o == 1, "R4 hold met", hold_met_o, 1);
    endtask

    task automatic t_irq();
        logic [3:0] c; logic [2:0] s;
        ir_scan(I_INT, 0, c);
        repeat (6) @(posedge clk); #1;
        chk(irq_o == 1, "R5 irq set", irq_o, 1);
        chk(irq_code_o == 12'h600, "R5 irq code", irq_code_o, 12'h600);
        dr_scan(3'b110, s);
        chk(s == 3'b101, "R7 interrupt data register", s, 3'b101);
        ir_scan(I_BYP, 0, c);
        repeat (6) @(posedge clk); #1;
        chk(irq_o == 1, "R6 irq sticky across IR load", irq_o, 1);
    endtask

    task automatic t_tlr();
        logic o; logic [2:0] s;
        for (int i = 0; i < 5; i++) tap_step(1, 0, o);
        tap_step(0, 0, o);
        repeat (6) @(posedge clk); #1;
        chk(dbg_reset_o == 1 && irq_o == 1, "R8 TLR keeps outputs",
            {dbg_reset_o, irq_o}, 2'b11);
        dr_scan(3'b111, s);
        chk(s == 3'b110, "R1 TLR loads bypass", s, 3'b110);
    endtask

    task automatic t_trst();
        logic o; logic [3:0] c; logic [2:0] s;
        ir_scan(I_INT, 0, c);
        trst_n = 1'b0;
        repeat (3) @(posedge clk); #1;
        trst_n = 1'b1;
        tap_step(0, 0, o);
        dr_scan(3'b011, s);
        chk(s == 3'b110, "R1 TRST loads bypass", s, 3'b110);
        chk(dbg_reset_o == 1 && irq_o == 1, "R8 TRST keeps outputs",
            {dbg_reset_o, irq_o}, 2'b11);
    endtask

    task automatic t_negate();
        logic [3:0] c;
        ir_scan(I_ROFF, 0, c);
        chk(dbg_reset_o == 0, "R3 reset negate", dbg_reset_o, 0);
        repeat (6) @(posedge clk); #1;
        chk(hold_met_o == 0, "R4 hold drops", hold_met_o, 0);
    endtask

    task automatic t_unknown();
        logic [3:0] c; logic [2:0] s;
        ir_scan(I_ODD, 0, c);
        dr_scan(3'b001, s);
        chk(s == 3'b010, "R2 unknown acts as bypass", s, 3'b010);
        chk(dbg_reset_o == 0 && irq_o == 1, "R3 unknown no effect",
            {dbg_reset_o, irq_o}, 2'b01);
    endtask

    task automatic t_clear();
        sw_clr = 1'b1;
        repeat (6) @(posedge clk); #1;
        chk(irq_o == 0, "R6 software clear", irq_o, 0);
        chk(irq_code_o == 0, "R5 code idle", irq_code_o, 0);
        sw_clr = 1'b0;
        repeat (6) @(posedge clk); #1;
    endtask

    task automatic t_collide();
        logic [3:0] c;
        ir_scan(I_INT, 1, c);
        repeat (8) @(posedge clk); #1;
        chk(irq_o == 1, "R9 set wins", irq_o, 1);
        sw_clr = 1'b0;
        repeat (8) @(posedge clk); #1;
        chk(irq_o == 1, "R9 still set", irq_o, 1);
    endtask

    initial begin
        logic o;
        repeat (8) @(posedge clk); #1;
        trst_n = 1'b1; sys_rst_n = 1'b1;
        repeat (4) @(posedge clk); #1;
        t_reset_state();
        tap_step(0, 0, o);
        t_ir_capture();
        t_reset_ctrl();
        t_irq();
        t_tlr();
        t_trst();
        t_negate();
        t_unknown();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule